// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the floating-point control and status state of a scalar core: a three-bit dynamic rounding mode and five sticky exception flags. Software reaches that state through a CSR access port. The port decodes an address, an operation (read, write, bit-set or bit-clear), an operand and the privilege of the requester. It answers in the same cycle with the value held before the access and an illegal indication. The same storage is visible through three addresses: the combined register, the rounding field on its own, and the flags on their own.

The floating-point unit reports the exceptions of each completed operation on a second port. Those flags are ORed into the stored flags and stay set until software clears them. A third, purely combinational port resolves an instruction's rounding field into the mode to use. The dynamic code takes the stored mode. The port flags reserved codes and a reserved stored mode as illegal. Traps, arithmetic and pipeline ordering belong to the surrounding core.

Top module: `fpcsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the stored rounding mode and all five flags to zero.
- R2: Address 0x003 reads as {24'b0, mode[2:0], flags[4:0]}, with the mode at bits 7:5. Address 0x002 reads as the mode zero-extended from bits 2:0. Address 0x001 reads as the flags zero-extended from bits 4:0. All three alias one storage. Read data is zero when no access is presented or the access is illegal.
- R3: The operation codes are: 2'b00 read only, 2'b01 write operand, 2'b10 set the bits that are 1 in the operand, 2'b11 clear the bits that are 1 in the operand. The read data returned is always the value from before the access modifies anything.
- R4: A write ignores operand bits above the width of the addressed view: bits 31:8 at 0x003, bits 31:3 at 0x002, and bits 31:5 at 0x001.
- R5: Flag bits from 4 down to 0 are invalid operation, divide by zero, overflow, underflow and inexact. The FPU flag input uses the same order. When its valid strobe is high, the input is ORed into the stored flags at the next clock edge.
- R6: A stored flag stays set until a CSR write or clear at 0x001 or 0x003 removes it. Later FPU reports and other accesses leave it set.
- R7: When a CSR access changes the flags in the same cycle as an FPU report, the new flags are the CSR result ORed with the reported flags.
- R8: An access is illegal when the address is not 0x001, 0x002 or 0x003, or when the privilege code is 2'b10. Valid privilege codes are 2'b00 user, 2'b01 supervisor and 2'b11 machine. An illegal access raises the illegal output in the same cycle and leaves the stored state unchanged.
- R9: Instruction rounding codes 000 to 100 pass straight to the mode output. Codes 101 and 110 raise the rounding illegal output and drive the mode output to 000.
- R10: Instruction rounding code 111 outputs the stored mode. If the stored mode is 101, 110 or 111, the rounding illegal output is raised instead and the mode output is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| csr_wdata | input | 32 | Operand or bit mask |
| csr_priv | input | 2 | Privilege of the requester |
| csr_rdata | output | 32 | Value before modification |
| csr_illegal | output | 1 | Access rejected |
| fpu_flags_valid | input | 1 | FPU exception report present |
| fpu_flags | input | 5 | Exceptions raised by the completed operation |
| inst_rm | input | 3 | Rounding field of the instruction |
| rm_out | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Rounding field or stored mode is reserved |

## Verification
A write at the combined address followed by reads at the two narrow addresses catches a design with the aliasing or the field placement wrong. Such a design returns the mode in the flag bits, or keeps upper operand bits. An FPU report in the same cycle as a CSR clear of the flags targets the merge. A design that lets the CSR result win drops the reported exception from the next read. The bench drives the dynamic rounding code while the stored mode holds a reserved value. A resolver that checks only the instruction field would pass 101 to 111 through as legal. Random traffic mixes bad addresses and the reserved privilege with set and clear masks. A design that commits a rejected access, or that returns the modified rather than the prior value, shows a read-data mismatch.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int RM_W   = 3;
    localparam int FLAG_W = 5;
    localparam int ADDR_W = 12;
    localparam int VIEW_W = RM_W + FLAG_W;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 12'h001;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 12'h002;
    localparam logic [ADDR_W-1:0] ADDR_FULL  = 12'h003;

    localparam logic [1:0] PRIV_RESERVED = 2'b10;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        VIEW_NONE,
        VIEW_FLAGS,
        VIEW_MODE,
        VIEW_FULL
    } csr_view_e;

    typedef struct packed {
        logic [RM_W-1:0]   mode;
        logic [FLAG_W-1:0] flags;
    } fp_state_t;

endpackage

// File: rtl/fpcsr_access.sv
module fpcsr_access
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 csr_valid,
    input  logic [ADDR_W-1:0]    csr_addr,
    input  logic [1:0]           csr_op,
    input  logic [XLEN-1:0]      csr_wdata,
    input  logic [1:0]           csr_priv,
    input  fp_state_t            state_q,
    output logic [XLEN-1:0]      csr_rdata,
    output logic                 csr_illegal,
    output logic                 mode_we,
    output logic [RM_W-1:0]      mode_new,
    output logic                 flags_we,
    output logic [FLAG_W-1:0]    flags_new
);

    csr_view_e         view;
    logic              priv_ok;
    logic              commit;
    logic [VIEW_W-1:0] old_view;
    logic [VIEW_W-1:0] operand;
    logic [VIEW_W-1:0] new_view;
    logic              unused_wdata;

    assign unused_wdata = ^csr_wdata[XLEN-1:VIEW_W];
    assign operand      = csr_wdata[VIEW_W-1:0];

    always_comb begin
        unique case (csr_addr)
            ADDR_FLAGS: view = VIEW_FLAGS;
            ADDR_MODE:  view = VIEW_MODE;
            ADDR_FULL:  view = VIEW_FULL;
            default:    view = VIEW_NONE;
        endcase
    end

    always_comb begin
        priv_ok     = (csr_priv != PRIV_RESERVED);
        csr_illegal = csr_valid && ((view == VIEW_NONE) || !priv_ok);
        commit      = csr_valid && !csr_illegal;

        old_view = '0;
        unique case (view)
            VIEW_FLAGS: old_view[FLAG_W-1:0] = state_q.flags;
            VIEW_MODE:  old_view[RM_W-1:0]   = state_q.mode;
            VIEW_FULL:  old_view             = state_q;
            default:    old_view             = '0;
        endcase

        csr_rdata = '0;
        if (commit) begin
            csr_rdata[VIEW_W-1:0] = old_view;
        end

        unique case (csr_op_e'(csr_op))
            OP_WRITE: new_view = operand;
            OP_SET:   new_view = old_view | operand;
            OP_CLEAR: new_view = old_view & ~operand;
            default:  new_view = old_view;
        endcase

        mode_we   = commit && (csr_op != OP_READ)
                    && ((view == VIEW_MODE) || (view == VIEW_FULL));
        flags_we  = commit && (csr_op != OP_READ)
                    && ((view == VIEW_FLAGS) || (view == VIEW_FULL));
        mode_new  = (view == VIEW_FULL) ? new_view[VIEW_W-1:FLAG_W]
                                        : new_view[RM_W-1:0];
        flags_new = new_view[FLAG_W-1:0];
    end

endmodule

// File: rtl/fpcsr_round.sv
module fpcsr_round
    import fpcsr_pkg::*;
#(
    parameter logic [RM_W-1:0] DYN_CODE   = 3'b111,
    parameter logic [RM_W-1:0] FIRST_RSVD = 3'b101
) (
    input  logic [RM_W-1:0] inst_rm,
    input  logic [RM_W-1:0] stored_mode,
    output logic [RM_W-1:0] rm_out,
    output logic            rm_illegal
);

    logic [RM_W-1:0] candidate;

    always_comb begin
        candidate  = (inst_rm == DYN_CODE) ? stored_mode : inst_rm;
        rm_illegal = (candidate >= FIRST_RSVD);
        rm_out     = rm_illegal ? '0 : candidate;
    end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_valid,
    input  logic [11:0]       csr_addr,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [1:0]        csr_priv,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    input  logic              fpu_flags_valid,
    input  logic [4:0]        fpu_flags,
    input  logic [2:0]        inst_rm,
    output logic [2:0]        rm_out,
    output logic              rm_illegal
);

    fp_state_t         state_d;
    fp_state_t         state_q;
    logic              mode_we;
    logic [RM_W-1:0]   mode_new;
    logic              flags_we;
    logic [FLAG_W-1:0] flags_new;

    fpcsr_access #(
        .XLEN (XLEN)
    ) u_access (
        .csr_valid   (csr_valid),
        .csr_addr    (csr_addr),
        .csr_op      (csr_op),
        .csr_wdata   (csr_wdata),
        .csr_priv    (csr_priv),
        .state_q     (state_q),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .mode_we     (mode_we),
        .mode_new    (mode_new),
        .flags_we    (flags_we),
        .flags_new   (flags_new)
    );

    fpcsr_round u_round (
        .inst_rm     (inst_rm),
        .stored_mode (state_q.mode),
        .rm_out      (rm_out),
        .rm_illegal  (rm_illegal)
    );

    always_comb begin
        state_d = state_q;
        if (mode_we) begin
            state_d.mode = mode_new;
        end
        if (flags_we) begin
            state_d.flags = flags_new;
        end
        if (fpu_flags_valid) begin
            state_d.flags = state_d.flags | fpu_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_valid,
    input logic [11:0]     csr_addr,
    input logic [1:0]      csr_op,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic            fpu_flags_valid,
    input logic [4:0]      fpu_flags,
    input logic [2:0]      inst_rm,
    input logic [2:0]      rm_out,
    input logic            rm_illegal,
    input logic [2:0]      mode_q,
    input logic [4:0]      flags_q
);

    logic flag_access;
    assign flag_access = csr_valid && !csr_illegal && (csr_op != 2'b00)
                         && (csr_addr != 12'h002);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mode_q == 3'b000) && (flags_q == 5'b00000));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (csr_rdata[XLEN-1:8] == '0));

    assert_mode_view_narrow_R2: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && !csr_illegal && csr_addr == 12'h002) |-> (csr_rdata[XLEN-1:3] == '0));

    assert_fpu_accrue_R5: assert property (@(posedge clk) disable iff (rst)
        fpu_flags_valid |=> ((flags_q & $past(fpu_flags)) == $past(fpu_flags)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !flag_access |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_illegal_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_illegal && !fpu_flags_valid) |=> ($stable(mode_q) && $stable(flags_q)));

    assert_illegal_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_rdata == '0));

    assert_rsvd_inst_R9: assert property (@(posedge clk) disable iff (rst)
        (inst_rm == 3'b101 || inst_rm == 3'b110) |-> (rm_illegal && rm_out == 3'b000));

    assert_dyn_resolve_R10: assert property (@(posedge clk) disable iff (rst)
        (inst_rm == 3'b111 && mode_q < 3'b101) |-> (!rm_illegal && rm_out == mode_q));

    assert_dyn_rsvd_R10: assert property (@(posedge clk) disable iff (rst)
        (inst_rm == 3'b111 && mode_q >= 3'b101) |-> rm_illegal);

endmodule

bind fpcsr_unit fpcsr_checker #(.XLEN(XLEN)) u_fpcsr_checker (
    .clk             (clk),
    .rst             (rst),
    .csr_valid       (csr_valid),
    .csr_addr        (csr_addr),
    .csr_op          (csr_op),
    .csr_rdata       (csr_rdata),
    .csr_illegal     (csr_illegal),
    .fpu_flags_valid (fpu_flags_valid),
    .fpu_flags       (fpu_flags),
    .inst_rm         (inst_rm),
    .rm_out          (rm_out),
    .rm_illegal      (rm_illegal),
    .mode_q          (state_q.mode),
    .flags_q         (state_q.flags)
);

// File: tb/tb_fpcsr_unit.sv
`timescale 1ns/1ps
module tb_fpcsr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_valid;
    logic [11:0] csr_addr;
    logic [1:0]  csr_op;
    logic [31:0] csr_wdata;
    logic [1:0]  csr_priv;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        fpu_flags_valid;
    logic [4:0]  fpu_flags;
    logic [2:0]  inst_rm;
    logic [2:0]  rm_out;
    logic        rm_illegal;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_mode;
    logic [4:0] m_flags;
    logic [31:0] last_rdata;

    always #5 clk = ~clk;

    fpcsr_unit dut (
        .clk             (clk),
        .rst             (rst),
        .csr_valid       (csr_valid),
        .csr_addr        (csr_addr),
        .csr_op          (csr_op),
        .csr_wdata       (csr_wdata),
        .csr_priv        (csr_priv),
        .csr_rdata       (csr_rdata),
        .csr_illegal     (csr_illegal),
        .fpu_flags_valid (fpu_flags_valid),
        .fpu_flags       (fpu_flags),
        .inst_rm         (inst_rm),
        .rm_out          (rm_out),
        .rm_illegal      (rm_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic acc_legal(input logic v, input logic [11:0] a,
                                       input logic [1:0] p);
        return v && (a == 12'h001 || a == 12'h002 || a == 12'h003) && (p != 2'b10);
    endfunction

    function automatic logic [31:0] view_value(input logic [11:0] a);
        case (a)
            12'h001: return {27'b0, m_flags};
            12'h002: return {29'b0, m_mode};
            12'h003: return {24'b0, m_mode, m_flags};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_round(input logic [2:0] irm);
        logic [2:0] c;
        c = (irm == 3'b111) ? m_mode : irm;
        if (c >= 3'b101) return {1'b1, 3'b000};
        return {1'b0, c};
    endfunction

    task automatic cycle(input string tag, input logic v, input logic [11:0] a,
                         input logic [1:0] op, input logic [31:0] wd,
                         input logic [1:0] p, input logic fv, input logic [4:0] ff,
                         input logic [2:0] irm);
        logic        legal;
        logic [31:0] oldv;
        logic [31:0] newv;
        logic [3:0]  er;
        @(negedge clk);
        csr_valid = v; csr_addr = a; csr_op = op; csr_wdata = wd;
        csr_priv = p; fpu_flags_valid = fv; fpu_flags = ff; inst_rm = irm;
        #1;
        legal = acc_legal(v, a, p);
        oldv  = legal ? view_value(a) : 32'b0;
        er    = exp_round(irm);
        check(tag, "csr_rdata", csr_rdata, oldv);
        check(tag, "csr_illegal", {31'b0, csr_illegal}, {31'b0, v && !legal});
        check(tag, "rm_out", {29'b0, rm_out}, {29'b0, er[2:0]});
        check(tag, "rm_illegal", {31'b0, rm_illegal}, {31'b0, er[3]});
        last_rdata = csr_rdata;
        if (legal && op != 2'b00) begin
            case (op)
                2'b01:   newv = wd;
                2'b10:   newv = oldv | wd;
                default: newv = oldv & ~wd;
            endcase
            if (a == 12'h001) m_flags = newv[4:0];
            if (a == 12'h002) m_mode  = newv[2:0];
            if (a == 12'h003) begin
                m_mode  = newv[7:5];
                m_flags = newv[4:0];
            end
        end
        if (fv) m_flags = m_flags | ff;
        @(posedge clk);
    endtask

    task automatic idle();
        cycle("R6", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    endtask

    initial begin
        #(1_500_000);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_1234);
        rst = 1'b1;
        csr_valid = 1'b0; csr_addr = '0; csr_op = '0; csr_wdata = '0;
        csr_priv = '0; fpu_flags_valid = 1'b0; fpu_flags = '0; inst_rm = '0;
        m_mode = '0; m_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state read through the combined view
        cycle("R1", 1'b1, 12'h003, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b111);
        check("R1", "reset full read", last_rdata, 32'h0);

        // R4: write all ones at 0x003 keeps only 8 bits
        cycle("R4", 1'b1, 12'h003, 2'b01, 32'hFFFF_FFFF, 2'b11, 1'b0, 5'b0, 3'b000);
        cycle("R4", 1'b1, 12'h003, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R4", "full after all-ones write", last_rdata, 32'h0000_00FF);
        // R2: aliasing of the narrow views
        cycle("R2", 1'b1, 12'h002, 2'b00, 32'b0, 2'b01, 1'b0, 5'b0, 3'b000);
        check("R2", "mode view", last_rdata, 32'h7);
        cycle("R2", 1'b1, 12'h001, 2'b00, 32'b0, 2'b01, 1'b0, 5'b0, 3'b000);
        check("R2", "flags view", last_rdata, 32'h1F);

        // R10: dynamic code with reserved stored mode 111
        cycle("R10", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b111);

        // R3: clear flags via 0x001, returns old value
        cycle("R3", 1'b1, 12'h001, 2'b11, 32'hFFFF_FFFF, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R3", "clear returns prior", last_rdata, 32'h1F);
        cycle("R3", 1'b1, 12'h003, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R3", "full after clear", last_rdata, 32'hE0);

        // R4: narrow mode write ignores bits above 2:0
        cycle("R4", 1'b1, 12'h002, 2'b01, 32'hFFFF_FFFB, 2'b00, 1'b0, 5'b0, 3'b000);
        cycle("R10", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b111);
        check("R10", "dyn resolves stored", {29'b0, rm_out}, 32'h3);
        cycle("R9", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b100);
        cycle("R9", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b101);
        cycle("R9", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b110);

        // R5 / R6: accrual and stickiness
        cycle("R5", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b1, 5'b10000, 3'b000);
        cycle("R5", 1'b0, 12'h000, 2'b00, 32'b0, 2'b00, 1'b1, 5'b00001, 3'b000);
        idle();
        cycle("R6", 1'b1, 12'h002, 2'b01, 32'h0, 2'b00, 1'b1, 5'b00000, 3'b000);
        cycle("R6", 1'b1, 12'h001, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R6", "flags held", last_rdata, 32'h11);

        // R7: CSR clear and FPU report in one cycle
        cycle("R7", 1'b1, 12'h001, 2'b01, 32'h0, 2'b00, 1'b1, 5'b00100, 3'b000);
        cycle("R7", 1'b1, 12'h001, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R7", "merge keeps fpu flag", last_rdata, 32'h04);

        // R8: bad address and reserved privilege
        cycle("R8", 1'b1, 12'h004, 2'b01, 32'hFF, 2'b11, 1'b0, 5'b0, 3'b000);
        cycle("R8", 1'b1, 12'h003, 2'b01, 32'hFF, 2'b10, 1'b0, 5'b0, 3'b000);
        cycle("R8", 1'b1, 12'h000, 2'b10, 32'hFF, 2'b00, 1'b0, 5'b0, 3'b000);
        cycle("R8", 1'b1, 12'h003, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b000);
        check("R8", "state after rejected", last_rdata, 32'h04);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            logic [31:0] wd;
            int unsigned sel;
            sel = $urandom % 8;
            case (sel)
                0, 1:    a = 12'h003;
                2, 3:    a = 12'h001;
                4, 5:    a = 12'h002;
                6:       a = 12'h000;
                default: a = 12'($urandom);
            endcase
            wd = ($urandom % 2 == 0) ? $urandom : ($urandom & 32'hFF);
            cycle((sel == 6 || sel == 7) ? "R8" : "R3",
                  ($urandom % 4) != 0, a, 2'($urandom), wd, 2'($urandom),
                  ($urandom % 3) == 0, 5'($urandom), 3'($urandom));
        end

        // R1: reset in the middle of activity
        cycle("R1", 1'b1, 12'h003, 2'b01, 32'hA5, 2'b00, 1'b0, 5'b0, 3'b000);
        @(negedge clk);
        rst = 1'b1;
        csr_valid = 1'b0; fpu_flags_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mode = '0; m_flags = '0;
        cycle("R1", 1'b1, 12'h003, 2'b00, 32'b0, 2'b00, 1'b0, 5'b0, 3'b111);
        check("R1", "full after second reset", last_rdata, 32'h0);

        summary();
        $finish;
    end

endmodule